// File: doc/BRIEF.md
# SPI Flash Command Cycle Engine

This block runs one serial-flash command cycle at a time on behalf of a host that programs it through a simple synchronous register port. The host fills an eight-entry opcode table, in which every entry carries a two-bit kind code. It also sets an optional prefix opcode, a flash address and a data buffer of up to 64 bytes. It then writes a control word that has its go bit set. The engine drives the serial clock, chip select and output data line in SPI mode 0, and samples the input data line. A cycle is the opcode, an optional three-byte address and an optional data phase. Bytes received in a read are placed in the buffer, and completion is reported through sticky status flags.

A cycle can be made atomic. In that case the prefix opcode (a write enable, for instance) goes out as a frame of its own, and the main frame follows straight after it inside the same engine sequence, so no other command can run between them. A lock bit freezes the opcode table, the kind codes and the prefix. From then on only commands already in the table can be issued, until the next reset. A speed bit picks between two serial clock rates, each a parameterized number of system cycles per half period.

Top module: `spi_cycle_engine`

## Requirements
- R1: After reset the status word reads 0, chip select is high and the serial clock is low.
- R2: Control word (offset 0): bit 0 go, bit 1 atomic, bit 2 data phase enable, bit 3 fast clock, bits 6:4 table index, bits 13:8 data byte count minus one. On go, the first byte of the main frame is the table entry picked by the index. Table entries 0..3 sit at offset 3 and entries 4..7 at offset 4, entry k of a word in bits 8k+7:8k.
- R3: Kind codes live at offset 5, two bits per entry, with entry i in bits 2i+1:2i. 0 is read without address, 1 is write without address, 2 is read with address and 3 is write with address. For an address kind, the opcode is followed by bits 23:16, 15:8 and 7:0 of the address register (offset 2). Bits above 23 are ignored.
- R4: With the data phase enabled, count+1 data bytes follow (from 1 to 64). A write kind sends buffer bytes 0..count. A read kind sends zero bytes. Buffer byte b sits at offset 16 + b/4, in bits 8(b mod 4)+7:8(b mod 4).
- R5: In a read kind, the byte received in data position i is stored into buffer byte i before the done flag rises.
- R6: Status (offset 1) holds bit 0 busy, bit 1 done and bit 2 error. Writing 1 to bit 1 or to bit 2 clears that flag, and writing 0 leaves it unchanged. Done rises in the same cycle that busy falls.
- R7: With the atomic bit set, the prefix opcode (offset 6, bits 7:0) is sent alone in a frame of its own. Chip select then stays high for at least four serial-clock half periods before the main frame begins.
- R8: Writing 1 to bit 0 of offset 7 sets the lock, which reads back as 1 until reset. While the lock is set, writes to offsets 3, 4, 5 and 6 are ignored.
- R9: The serial clock half period is SLOW_HALF system cycles when the fast bit is clear, and FAST_HALF system cycles when it is set.
- R10: A control write with go set while busy is ignored, and it sets the error flag.
- R11: SPI mode 0 is used. The clock is low whenever chip select is high, the output data line changes only while the clock is low, and input data is sampled on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| spiSck | output | 1 | Serial clock |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
Register reads are combinational, so the bench samples a read one time unit after it sets the offset on a falling clock edge. A write takes effect at the next rising edge. The error flag caused by a go written during a busy cycle can be seen on the very next read. Frame contents, clock period and chip-select gap are recorded by a responder model on the serial lines as they happen. They are compared only once the done flag reads back set, since every frame has closed before done rises. Buffer contents from reads are checked after done for the same reason.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int BUF_BYTES = 64;
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] OFF_ADDR = 5'd2;
  localparam logic [ADDR_W-1:0] OFF_MLO = 5'd3;
  localparam logic [ADDR_W-1:0] OFF_MHI = 5'd4;
  localparam logic [ADDR_W-1:0] OFF_KIND = 5'd5;
  localparam logic [ADDR_W-1:0] OFF_PRE = 5'd6;
  localparam logic [ADDR_W-1:0] OFF_LOCK = 5'd7;

  typedef enum logic [1:0] {SEL_PRE, SEL_OPC, SEL_ADR, SEL_DAT} txsel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    txsel_e sel;
    logic [IDX_W-1:0] idx;
    logic rd;
    logic csLow;
  } stb_t;

  // register events decoded by the datapath
  typedef struct packed {
    logic go;
    logic atomic;
    logic clrDone;
    logic clrErr;
  } ev_t;

  typedef struct packed {
    logic dataOn;
    logic [1:0] kind;
    logic [IDX_W-1:0] last;
  } cfg_t;
endpackage

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  stb_t              stb,
  input  logic              busy,
  input  logic              doneF,
  input  logic              errF,
  input  logic              spiMiso,
  output ev_t               ev,
  output cfg_t              cfg,
  output logic              tick,
  output logic              byteDone,
  output logic              spiSck,
  output logic              spiMosi
);
  localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int DIV_W = $clog2(MAXH + 1);
  localparam logic [DIV_W-1:0] SLOW_T = DIV_W'(SLOW_HALF - 1);
  localparam logic [DIV_W-1:0] FAST_T = DIV_W'(FAST_HALF - 1);

  logic ctrlAtomic, ctrlData, ctrlFast, locked;
  logic [2:0] ctrlIdx;
  logic [IDX_W-1:0] ctrlCnt;
  logic [23:0] addrQ;
  logic [15:0] kindQ;
  logic [7:0] prefixQ;
  logic [7:0] menu [8];
  logic [7:0] bufMem [BUF_BYTES];
  logic [DIV_W-1:0] divCnt;
  logic engOn;
  logic [2:0] bitCnt;
  logic [7:0] shTx, shRx, txByte;
  logic unusedOk;

  logic isCtrl, isStat, isAddr, isBuf;
  assign isCtrl = (regAddr == OFF_CTRL);
  assign isStat = (regAddr == OFF_STAT);
  assign isAddr = (regAddr == OFF_ADDR);
  assign isBuf = regAddr[ADDR_W-1];
  assign unusedOk = ^{regWrData[31:24], ctrlAtomic};

  assign ev.go = regWe && isCtrl && regWrData[0];
  assign ev.atomic = regWrData[1];
  assign ev.clrDone = regWe && isStat && regWrData[1];
  assign ev.clrErr = regWe && isStat && regWrData[2];
  assign cfg.dataOn = ctrlData;
  assign cfg.kind = kindQ[{ctrlIdx, 1'b0} +: 2];
  assign cfg.last = ctrlCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {ctrlAtomic, ctrlData, ctrlFast, locked} <= '0;
      ctrlIdx <= '0;
      ctrlCnt <= '0;
      addrQ <= '0;
      kindQ <= '0;
      prefixQ <= '0;
      for (int k = 0; k < 8; k++) menu[k] <= '0;
    end else if (regWe) begin
      if (isCtrl && !busy) begin
        ctrlAtomic <= regWrData[1];
        ctrlData <= regWrData[2];
        ctrlFast <= regWrData[3];
        ctrlIdx <= regWrData[6:4];
        ctrlCnt <= regWrData[8 +: IDX_W];
      end
      if (isAddr && !busy) addrQ <= regWrData[23:0];
      if (!locked) begin
        for (int k = 0; k < 4; k++) begin
          if (regAddr == OFF_MLO) menu[k] <= regWrData[8*k +: 8];
          if (regAddr == OFF_MHI) menu[k+4] <= regWrData[8*k +: 8];
        end
        if (regAddr == OFF_KIND) kindQ <= regWrData[15:0];
        if (regAddr == OFF_PRE) prefixQ <= regWrData[7:0];
      end
      if (regAddr == OFF_LOCK && regWrData[0]) locked <= 1'b1;
    end
  end

  // byte-wide shift engine paced by a free-running half-period divider
  assign tick = (divCnt >= (ctrlFast ? FAST_T : SLOW_T));
  assign spiMosi = shTx[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      engOn <= 1'b0;
      spiSck <= 1'b0;
      bitCnt <= '0;
      shTx <= '0;
      shRx <= '0;
      byteDone <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      byteDone <= 1'b0;
      if (stb.start) begin
        engOn <= 1'b1;
        spiSck <= 1'b0;
        bitCnt <= '0;
        shTx <= txByte;
      end else if (engOn && tick) begin
        if (!spiSck) begin
          spiSck <= 1'b1;
          shRx <= {shRx[6:0], spiMiso};
        end else begin
          spiSck <= 1'b0;
          if (bitCnt == 3'd7) begin
            engOn <= 1'b0;
            byteDone <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            shTx <= {shTx[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_comb begin
    case (stb.sel)
      SEL_PRE: txByte = prefixQ;
      SEL_OPC: txByte = menu[ctrlIdx];
      SEL_ADR: begin
        case (stb.idx[1:0])
          2'd0: txByte = addrQ[23:16];
          2'd1: txByte = addrQ[15:8];
          default: txByte = addrQ[7:0];
        endcase
      end
      default: txByte = stb.rd ? 8'h00 : bufMem[stb.idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (regWe && isBuf)
      for (int k = 0; k < 4; k++)
        bufMem[{regAddr[ADDR_W-2:0], k[1:0]}] <= regWrData[8*k +: 8];
    if (byteDone && stb.sel == SEL_DAT && stb.rd) bufMem[stb.idx] <= shRx;
  end

  always_comb begin
    regRdData = '0;
    if (isBuf) begin
      for (int k = 0; k < 4; k++)
        regRdData[8*k +: 8] = bufMem[{regAddr[ADDR_W-2:0], k[1:0]}];
    end else begin
      case (regAddr)
        OFF_CTRL: regRdData = {18'd0, 2'(ctrlCnt), 1'b0, ctrlIdx, ctrlFast, ctrlData, ctrlAtomic, 1'b0};
        OFF_STAT: regRdData = {29'd0, errF, doneF, busy};
        OFF_ADDR: regRdData = {8'd0, addrQ};
        OFF_MLO: regRdData = {menu[3], menu[2], menu[1], menu[0]};
        OFF_MHI: regRdData = {menu[7], menu[6], menu[5], menu[4]};
        OFF_KIND: regRdData = {16'd0, kindQ};
        OFF_PRE: regRdData = {24'd0, prefixQ};
        OFF_LOCK: regRdData = {31'd0, locked};
        default: regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ev_t  ev,
  input  cfg_t cfg,
  input  logic tick,
  input  logic byteDone,
  output stb_t stb,
  output logic busy,
  output logic doneF,
  output logic errF
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GAP, S_OPC, S_ADR, S_DAT, S_TAIL} state_e;
  state_e state;
  logic [2:0] gapCnt;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      stb <= '0;
      gapCnt <= '0;
      doneF <= 1'b0;
      errF <= 1'b0;
    end else begin
      stb.start <= 1'b0;
      if (ev.clrDone) doneF <= 1'b0;
      if (ev.clrErr) errF <= 1'b0;
      if (ev.go && busy) errF <= 1'b1;
      case (state)
        S_IDLE: if (ev.go) begin
          stb.csLow <= 1'b1;
          stb.start <= 1'b1;
          stb.rd <= 1'b0;
          stb.idx <= '0;
          stb.sel <= ev.atomic ? SEL_PRE : SEL_OPC;
          state <= ev.atomic ? S_PRE : S_OPC;
        end
        S_PRE: if (byteDone) begin
          stb.csLow <= 1'b0;
          gapCnt <= '0;
          state <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (gapCnt == 3'd4) begin
            stb.csLow <= 1'b1;
            stb.start <= 1'b1;
            stb.sel <= SEL_OPC;
            state <= S_OPC;
          end else gapCnt <= gapCnt + 1'b1;
        end
        S_OPC, S_ADR: if (byteDone) begin
          if (state == S_OPC && cfg.kind[1]) begin
            stb.sel <= SEL_ADR;
            stb.idx <= '0;
            stb.start <= 1'b1;
            state <= S_ADR;
          end else if (state == S_ADR && stb.idx != 2) begin
            stb.idx <= stb.idx + 1'b1;
            stb.start <= 1'b1;
          end else if (cfg.dataOn) begin
            stb.sel <= SEL_DAT;
            stb.idx <= '0;
            stb.rd <= ~cfg.kind[0];
            stb.start <= 1'b1;
            state <= S_DAT;
          end else begin
            stb.csLow <= 1'b0;
            state <= S_TAIL;
          end
        end
        S_DAT: if (byteDone) begin
          if (stb.idx == cfg.last) begin
            stb.csLow <= 1'b0;
            state <= S_TAIL;
          end else begin
            stb.idx <= stb.idx + 1'b1;
            stb.start <= 1'b1;
          end
        end
        default: if (tick) begin
          doneF <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_cycle_engine.sv
module spi_cycle_engine
  import spi_eng_pkg::*;
#(
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [4:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        spiSck,
  output logic        spiCsN,
  output logic        spiMosi,
  input  logic        spiMiso
);
  stb_t stb;
  ev_t ev;
  cfg_t cfg;
  logic tick, byteDone, busyW, doneW, errW;

  spi_eng_dp #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stb), .busy(busyW),
    .doneF(doneW), .errF(errW), .spiMiso(spiMiso), .ev(ev), .cfg(cfg),
    .tick(tick), .byteDone(byteDone), .spiSck(spiSck), .spiMosi(spiMosi)
  );

  spi_eng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .cfg(cfg), .tick(tick),
    .byteDone(byteDone), .stb(stb), .busy(busyW), .doneF(doneW), .errF(errW)
  );

  assign spiCsN = ~stb.csLow;
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [4:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        spiSck,
  input logic        spiCsN,
  input logic        spiMosi,
  input logic        busy,
  input logic        doneF,
  input logic        errF
);
  // R11
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);
  // R11
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && $past(spiSck)) |-> $stable(spiMosi));
  // R10
  busy_go_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 5'd0 && regWrData[0] && busy) |=> errF);
  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneF) |-> (!busy && $past(busy)));
  // R1
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> spiCsN);
endmodule

bind spi_cycle_engine spi_eng_chk u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWrData(regWrData), .spiSck(spiSck), .spiCsN(spiCsN),
  .spiMosi(spiMosi), .busy(busyW), .doneF(doneW), .errF(errW)
);

// File: tb/tb_spi_cycle_engine.sv
module tb_spi_cycle_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_H = 3;
  localparam int FAST_H = 2;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, spiMiso = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic spiSck, spiCsN, spiMosi;

  spi_cycle_engine dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .spiSck(spiSck),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vecs = 0, fails = 0;
  int cyc = 0, lastRise = 0, lastPer = 0, hiCnt = 0, lastGap = 0;
  int bitPos = 0, frameNo = 0;
  logic [7:0] shIn = '0;
  logic [7:0] fb [4][72];
  int fLen [4];

  // bench model of programmed state
  logic [7:0] menuM [8];
  logic [15:0] kindM;
  logic [7:0] prefixM, bufM [64];
  logic [31:0] addrM;

  function automatic logic [7:0] respByte(int j);
    return 8'(j * 29 + 60);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (spiCsN) hiCnt++;
    else begin
      if (hiCnt > 0) lastGap = hiCnt;
      hiCnt = 0;
    end
  end

  always @(posedge spiSck) begin
    lastPer = cyc - lastRise;
    lastRise = cyc;
  end

  // responder: logs MOSI bytes per frame, returns respByte(n) for frame byte n
  always @(posedge spiSck or posedge spiCsN) begin
    if (spiCsN) begin
      if (bitPos > 0) begin
        fLen[frameNo % 4] = bitPos / 8;
        frameNo++;
      end
      bitPos = 0;
    end else begin
      shIn = {shIn[6:0], spiMosi};
      bitPos++;
      if (bitPos % 8 == 0) fb[frameNo % 4][bitPos/8 - 1] = shIn;
    end
  end

  always @(negedge spiSck or negedge spiCsN) begin
    logic [7:0] rb;
    rb = respByte(bitPos / 8);
    spiMiso = rb[7 - (bitPos % 8)];
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic loadRegs();
    wr(5'd3, {menuM[3], menuM[2], menuM[1], menuM[0]});
    wr(5'd4, {menuM[7], menuM[6], menuM[5], menuM[4]});
    wr(5'd5, {16'd0, kindM});
    wr(5'd6, {24'd0, prefixM});
    wr(5'd2, addrM);
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {bufM[4*w+3], bufM[4*w+2], bufM[4*w+1], bufM[4*w]});
  endtask

  task automatic waitDone();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(5'd1, s);
      if (s[1]) break;
    end
  endtask

  function automatic logic [31:0] ctrlWord(logic [2:0] idx, bit at, bit dat, bit fast, logic [5:0] last);
    return {18'd0, last, 1'b0, idx, fast, dat, at, 1'b1};
  endfunction

  // verify frames and buffer for a completed cycle started at frame number base
  task automatic verifyCycle(input int base, input logic [2:0] idx, input bit at, input bit dat,
                             input bit fast, input logic [5:0] last, input bit expErr);
    logic [1:0] k;
    int mf, n, bad, p;
    logic [7:0] e;
    logic [31:0] s, w;
    k = kindM[2*idx +: 2];
    n = 1 + (k[1] ? 3 : 0) + (dat ? int'(last) + 1 : 0);
    check(frameNo - base == (at ? 2 : 1), "R7 frame count", frameNo - base, at ? 2 : 1);
    if (at) begin
      check(fLen[base % 4] == 1 && fb[base % 4][0] == prefixM, "R7 prefix frame",
            fb[base % 4][0], prefixM);
      check(lastGap >= 4 * (fast ? FAST_H : SLOW_H), "R7 cs gap", lastGap, 4 * (fast ? FAST_H : SLOW_H));
    end
    mf = (base + (at ? 1 : 0)) % 4;
    check(fLen[mf] == n, "R3/R4 frame length", fLen[mf], n);
    check(fb[mf][0] == menuM[idx], "R2 opcode", fb[mf][0], menuM[idx]);
    bad = 0;
    for (int i = 1; i < n; i++) begin
      if (k[1] && i <= 3) e = addrM[8*(3-i) +: 8];
      else e = k[0] ? bufM[i - 1 - (k[1] ? 3 : 0)] : 8'h00;
      if (fb[mf][i] !== e) bad++;
    end
    check(bad == 0, "R3/R4 frame body", bad, 0);
    check(lastPer == 2 * (fast ? FAST_H : SLOW_H), "R9 sck period", lastPer, 2 * (fast ? FAST_H : SLOW_H));
    rd(5'd1, s);
    check(s[2:0] == {expErr, 2'b10}, "R6 status after cycle", s[2:0], {expErr, 2'b10});
    if (dat && !k[0]) begin
      p = 1 + (k[1] ? 3 : 0);
      bad = 0;
      for (int i = 0; i <= int'(last); i++) begin
        rd(5'(16 + i/4), w);
        bufM[i] = respByte(p + i);
        if (w[8*(i%4) +: 8] !== bufM[i]) bad++;
      end
      check(bad == 0, "R5 read data in buffer", bad, 0);
    end
    wr(5'd1, 32'h6);
  endtask

  task automatic runCycle(input logic [2:0] idx, input bit at, input bit dat, input bit fast, input logic [5:0] last);
    int base;
    base = frameNo;
    wr(5'd0, ctrlWord(idx, at, dat, fast, last));
    waitDone();
    verifyCycle(base, idx, at, dat, fast, last, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    logic [31:0] s, t;
    int base;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(5'd1, s);
    check(s == 0, "R1 status after reset", s, 0);
    check(spiCsN === 1'b1 && spiSck === 1'b0, "R1 pins idle", {spiCsN, spiSck}, 2'b10);

    for (int k = 0; k < 8; k++) menuM[k] = 8'(8'h10 + 17 * k);
    kindM = 16'he4e4; prefixM = 8'h06; addrM = 32'hAB123456;
    for (int b = 0; b < 64; b++) bufM[b] = 8'($urandom);
    loadRegs();

    // directed: full 64-byte write with address and prefix, slow clock
    runCycle(3'd3, 1'b1, 1'b1, 1'b0, 6'd63);
    // directed: full 64-byte read with address, fast clock
    runCycle(3'd2, 1'b0, 1'b1, 1'b1, 6'd63);
    // directed: opcode only (read kind, no data)
    runCycle(3'd0, 1'b0, 1'b0, 1'b0, 6'd0);

    // random cycles
    for (int it = 0; it < 24; it++) begin
      for (int k = 0; k < 8; k++) menuM[k] = 8'($urandom);
      kindM = 16'($urandom); prefixM = 8'($urandom); addrM = $urandom;
      for (int b = 0; b < 64; b++) bufM[b] = 8'($urandom);
      loadRegs();
      runCycle(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 6'($urandom % 12));
    end

    // R6 W1C behaviour
    wr(5'd0, ctrlWord(3'd1, 1'b0, 1'b0, 1'b1, 6'd0));
    waitDone();
    wr(5'd1, 32'h0);
    rd(5'd1, s);
    check(s[1] == 1'b1, "R6 write zero keeps done", s, 32'h2);
    wr(5'd1, 32'h2);
    rd(5'd1, s);
    check(s[2:0] == 3'b000, "R6 write one clears done", s, 0);

    // R10 go while busy
    kindM[5:4] = 2'd2;
    wr(5'd5, {16'd0, kindM});
    base = frameNo;
    wr(5'd0, ctrlWord(3'd2, 1'b0, 1'b1, 1'b0, 6'd20));
    repeat (10) @(negedge clk);
    wr(5'd0, ctrlWord(3'd5, 1'b1, 1'b0, 1'b1, 6'd0));
    rd(5'd1, s);
    check(s[2:0] == 3'b101, "R10 error while busy", s[2:0], 3'b101);
    waitDone();
    verifyCycle(base, 3'd2, 1'b0, 1'b1, 1'b0, 6'd20, 1'b1);

    // R8 lock
    wr(5'd7, 32'h1);
    rd(5'd7, s);
    check(s[0] == 1'b1, "R8 lock reads set", s, 1);
    rd(5'd3, t);
    wr(5'd3, ~t);
    wr(5'd5, 32'h0000_5a5a);
    wr(5'd6, 32'h0000_00c7);
    rd(5'd3, s);
    check(s == t, "R8 menu frozen", s, t);
    rd(5'd5, s);
    check(s[15:0] == kindM, "R8 kinds frozen", s[15:0], kindM);
    rd(5'd6, s);
    check(s[7:0] == prefixM, "R8 prefix frozen", s[7:0], prefixM);
    runCycle(3'd1, 1'b1, 1'b1, 1'b0, 6'd3);
    wr(5'd7, 32'h0);
    rd(5'd7, s);
    check(s[0] == 1'b1, "R8 lock persists", s, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule